// File: doc/BRIEF.md
# BCH Syndrome Calculator

This block forms the syndromes of a binary BCH codeword over GF(2^13) while the codeword streams past it one byte per beat. Each accepted byte updates all 2T syndrome accumulators at once. When the last byte of the codeword has been taken in, the block raises a one-cycle strobe and presents the full syndrome vector together with a flag that says whether any bit error is present. A decoder reads the vector during the strobe, or at any time before the next codeword starts, and passes it on to the later decode stages.

Each syndrome S_j (j = 1..2T) is the received polynomial evaluated at alpha^j, where alpha is a root of the field polynomial. The block folds one byte into every syndrome per beat with Horner's rule: it multiplies by alpha^(8j) and adds the constant-weighted bits of the new byte. There is no backpressure. The correction capability T and the codeword length in bytes are compile-time parameters.

Top module: `bch_syndrome_calc`

## Requirements
- R1: Field arithmetic uses x^13 + x^4 + x^3 + x + 1. S_j equals the received polynomial at alpha^j. Bit 7 of the first byte is the highest-order coefficient, and bit 0 of the last byte is the constant term. syn_vec holds S_j in bits [13j-1 : 13(j-1)].
- R2: Exactly 2T syndromes are produced. Every one of them is updated on each beat with in_valid high, so one byte is accepted per clock with no stall.
- R3: A beat with in_valid and in_sof high discards the previous accumulator contents. That beat's byte is the first byte of the new codeword.
- R4: syn_valid is high for exactly one cycle, the cycle after the beat that carries in_eoc, and it is low at all other times.
- R5: After the end-of-codeword beat, syn_vec and err_flag stay constant through idle cycles. syn_vec holds until the next in_sof beat, and err_flag holds until the next in_eoc beat.
- R6: While syn_valid is high, err_flag is 0 if every syndrome is zero and 1 if any syndrome is non-zero.
- R7: A cycle with in_valid low has no effect, whatever in_data, in_sof and in_eoc carry.
- R8: A new codeword may start on the cycle right after the end beat. During the strobe cycle the outputs still show the finished codeword, and the new codeword's result is computed without interference.
- R9: After reset, syn_valid and err_flag are 0 and syn_vec is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Beat qualifier for in_data, in_sof and in_eoc |
| in_sof | input | 1 | First byte of a codeword |
| in_eoc | input | 1 | Last byte of a codeword (beat CW_BYTES of the codeword) |
| in_data | input | DATA_W (8) | Codeword byte, bit 7 received first |
| syn_valid | output | 1 | One-cycle strobe: syndromes complete |
| syn_vec | output | 2*T*13 (104) | Packed syndromes, S_1 in the low bits |
| err_flag | output | 1 | 1 when the finished codeword has a non-zero syndrome |

## Verification
The two events that can share a cycle are the result strobe of one codeword and the start beat of the next. In that cycle the accumulators must still drive the finished syndromes, and on the same edge they must load the first byte of the new codeword. The bench provokes this by sending a codeword with errors and then, with no gap, an all-zero codeword. It judges the outcome in three places: the old vector and a set err_flag during the strobe, a strobe that lasts only that one cycle, and an all-zero vector with a clear err_flag once the second codeword ends. That last check shows that no residue from the first codeword survived the overlap.

// File: rtl/syn_pkg.sv
package syn_pkg;

  localparam int unsigned GF_M = 13;
  // low part of x^13 + x^4 + x^3 + x + 1
  localparam logic [GF_M-1:0] GF_POLY_LOW = 13'h001B;

  typedef logic [GF_M-1:0] elem_t;

  // multiply a field element by alpha (x)
  function automatic elem_t gf_mulx(input elem_t a);
    elem_t r;
    r = {a[GF_M-2:0], 1'b0};
    if (a[GF_M-1]) r = r ^ GF_POLY_LOW;
    return r;
  endfunction

  // a * alpha^e, elaboration-time use only
  function automatic elem_t gf_scale(input elem_t a, input int unsigned e);
    elem_t r;
    r = a;
    for (int unsigned i = 0; i < e; i++) r = gf_mulx(r);
    return r;
  endfunction

  function automatic elem_t gf_alpha_pow(input int unsigned e);
    return gf_scale(elem_t'(1), e);
  endfunction

endpackage

// File: rtl/syn_const_mul.sv
// Multiplies a variable field element by a constant K.
module syn_const_mul
  import syn_pkg::*;
#(
  parameter elem_t K = elem_t'(1)
) (
  input  elem_t a,
  output elem_t y
);

  elem_t col [GF_M];

  for (genvar i = 0; i < GF_M; i++) begin : g_col
    localparam elem_t COLV = gf_scale(K, i);
    assign col[i] = COLV;
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < GF_M; i++) begin
      if (a[i]) y = y ^ col[i];
    end
  end

endmodule

// File: rtl/syn_byte_term.sv
// Contribution of one byte to syndrome J: XOR over k of d[k] * alpha^(J*k).
module syn_byte_term
  import syn_pkg::*;
#(
  parameter int unsigned J      = 1,
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] d,
  output elem_t             term
);

  elem_t wgt [DATA_W];

  for (genvar k = 0; k < DATA_W; k++) begin : g_wgt
    localparam elem_t WV = gf_alpha_pow(J * k);
    assign wgt[k] = WV;
  end

  always_comb begin
    term = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (d[k]) term = term ^ wgt[k];
    end
  end

endmodule

// File: rtl/syn_accum.sv
// One syndrome accumulator: S <= S * alpha^(DATA_W*J) ^ term(byte).
module syn_accum
  import syn_pkg::*;
#(
  parameter int unsigned J      = 1,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_en,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output elem_t             syn_d,
  output elem_t             syn_q
);

  localparam elem_t STEP = gf_alpha_pow(DATA_W * J);

  elem_t scaled;
  elem_t term;
  elem_t base;

  syn_const_mul #(.K(STEP)) i_step (
    .a (syn_q),
    .y (scaled)
  );

  syn_byte_term #(.J(J), .DATA_W(DATA_W)) i_term (
    .d    (data),
    .term (term)
  );

  always_comb begin
    base  = start ? '0 : scaled;
    syn_d = base ^ term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q <= '0;
    end else if (beat_en) begin
      syn_q <= syn_d;
    end
  end

  // R3
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_en && start && (data == '0)) |=> (syn_q == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_en |=> $stable(syn_q));

endmodule

// File: rtl/syn_frame_ctl.sv
// Result strobe and codeword beat counting.
module syn_frame_ctl #(
  parameter int unsigned CW_BYTES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_en,
  input  logic sof,
  input  logic eoc,
  output logic done
);

  localparam int unsigned CNT_W = $clog2(CW_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;

  always_comb begin
    cnt_d  = sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
    done_d = beat_en && eoc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (beat_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_en && eoc) |-> (cnt_d == CNT_W'(CW_BYTES)));

  // R4
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(beat_en && eoc));

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/bch_syndrome_calc.sv
module bch_syndrome_calc
  import syn_pkg::*;
#(
  parameter int unsigned T        = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CW_BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_eoc,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     syn_valid,
  output logic [2*T*GF_M-1:0]      syn_vec,
  output logic                     err_flag
);

  localparam int unsigned NSYN = 2 * T;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [NSYN*GF_M-1:0] nxt_vec;

  for (genvar g = 0; g < NSYN; g++) begin : g_syn
    elem_t sd, sq;
    syn_accum #(.J(g + 1), .DATA_W(DATA_W)) i_acc (
      .clk     (clk),
      .rst_n   (rst_s),
      .beat_en (in_valid),
      .start   (in_sof),
      .data    (in_data),
      .syn_d   (sd),
      .syn_q   (sq)
    );
    assign nxt_vec[g*GF_M +: GF_M] = sd;
    assign syn_vec[g*GF_M +: GF_M] = sq;
  end

  syn_frame_ctl #(.CW_BYTES(CW_BYTES)) i_ctl (
    .clk     (clk),
    .rst_n   (rst_s),
    .beat_en (in_valid),
    .sof     (in_sof),
    .eoc     (in_eoc),
    .done    (syn_valid)
  );

  // error flag taken from the final syndromes on the end beat
  logic err_d, err_upd;
  always_comb begin
    err_upd = in_valid && in_eoc;
    err_d   = |nxt_vec;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      err_flag <= 1'b0;
    end else if (err_upd) begin
      err_flag <= err_d;
    end
  end

  // R6
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_s)
    syn_valid |-> (err_flag == (syn_vec != '0)));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !in_valid |=> $stable(err_flag));

endmodule

// File: tb/test_bch_syndrome_calc.sv
`timescale 1ns/1ps
module test_bch_syndrome_calc;

  localparam int T    = 4;
  localparam int NS   = 2 * T;
  localparam int CW   = 16;
  localparam int M    = 13;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid, in_sof, in_eoc;
  logic [7:0]      in_data;
  logic            syn_valid;
  logic [NS*M-1:0] syn_vec;
  logic            err_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]   cw [CW];
  logic [12:0]  exp_s [NS+1];
  logic         exp_err;

  always #2 clk = ~clk;

  bch_syndrome_calc #(.T(T), .DATA_W(8), .CW_BYTES(CW)) i_bch_syndrome_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eoc    (in_eoc),
    .in_data   (in_data),
    .syn_valid (syn_valid),
    .syn_vec   (syn_vec),
    .err_flag  (err_flag)
  );

  // ---------------- reference field math ----------------
  function automatic logic [12:0] r_xt(input logic [12:0] a);
    logic [12:0] r;
    r = {a[11:0], 1'b0};
    if (a[12]) r = r ^ 13'h001B;
    return r;
  endfunction

  function automatic logic [12:0] r_mul(input logic [12:0] a, input logic [12:0] b);
    logic [12:0] r;
    r = '0;
    for (int i = 12; i >= 0; i--) begin
      r = r_xt(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [12:0] r_apow(input int e);
    logic [12:0] r;
    r = 13'd1;
    for (int i = 0; i < (e % 8191); i++) r = r_xt(r);
    return r;
  endfunction

  task automatic calc_expected();
    exp_err = 1'b0;
    for (int j = 1; j <= NS; j++) begin
      logic [12:0] s, aj;
      aj = r_apow(j);
      s  = '0;
      for (int b = 0; b < CW; b++) begin
        for (int k = 7; k >= 0; k--) begin
          s = r_mul(s, aj) ^ {12'd0, cw[b][k]};
        end
      end
      exp_s[j] = s;
      if (s != '0) exp_err = 1'b1;
    end
  endtask

  // ---------------- check helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic chk_syn(input string req, input string what);
    for (int j = 1; j <= NS; j++) begin
      logic [12:0] a;
      a = syn_vec[(j-1)*M +: M];
      chk(a == exp_s[j], req, $sformatf("%s S%0d", what, j), 32'(a), 32'(exp_s[j]));
    end
  endtask

  task automatic idle_beat();
    in_valid = 1'b0; in_sof = 1'b0; in_eoc = 1'b0; in_data = 8'h00;
  endtask

  // sends cw[], leaving the last beat driven; gaps add junk idle beats
  task automatic send_cw(input bit gaps);
    for (int b = 0; b < CW; b++) begin
      if (gaps && (b % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b1; in_eoc = 1'b1; in_data = 8'($urandom);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (b == 0);
      in_eoc   = (b == CW - 1);
      in_data  = cw[b];
    end
  endtask

  // one negedge after the end beat: strobe window
  task automatic check_result(input string req, input string what);
    @(negedge clk);
    chk(syn_valid == 1'b1, "R4", {what, " strobe"}, 32'(syn_valid), 32'd1);
    chk_syn(req, what);
    chk(err_flag == exp_err, "R6", {what, " err_flag"}, 32'(err_flag), 32'(exp_err));
    idle_beat();
    @(negedge clk);
    chk(syn_valid == 1'b0, "R4", {what, " strobe single"}, 32'(syn_valid), 32'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(syn_valid == 1'b0, "R9", "reset syn_valid", 32'(syn_valid), 32'd0);
    chk(err_flag == 1'b0, "R9", "reset err_flag", 32'(err_flag), 32'd0);
    chk(syn_vec == '0, "R9", "reset syn_vec", 32'(syn_vec[31:0]), 32'd0);
  endtask

  task automatic t_zero_word();
    for (int b = 0; b < CW; b++) cw[b] = 8'h00;
    calc_expected();
    send_cw(1'b0);
    check_result("R6", "zero word");
  endtask

  task automatic t_last_bit();
    for (int b = 0; b < CW; b++) cw[b] = 8'h00;
    cw[CW-1] = 8'h01;
    calc_expected();
    send_cw(1'b0);
    @(negedge clk);
    for (int j = 1; j <= NS; j++) begin
      logic [12:0] a;
      a = syn_vec[(j-1)*M +: M];
      chk(a == 13'd1, "R1", $sformatf("last bit S%0d", j), 32'(a), 32'd1);
    end
    chk(err_flag == 1'b1, "R6", "last bit err_flag", 32'(err_flag), 32'd1);
    idle_beat();
  endtask

  task automatic t_first_bit();
    for (int b = 0; b < CW; b++) cw[b] = 8'h00;
    cw[0] = 8'h80;
    send_cw(1'b0);
    @(negedge clk);
    for (int j = 1; j <= NS; j++) begin
      logic [12:0] a, e;
      a = syn_vec[(j-1)*M +: M];
      e = r_apow(j * (8 * CW - 1));
      chk(a == e, "R1", $sformatf("first bit S%0d", j), 32'(a), 32'(e));
    end
    idle_beat();
  endtask

  task automatic t_random(input int n);
    for (int r = 0; r < n; r++) begin
      for (int b = 0; b < CW; b++) cw[b] = 8'($urandom);
      calc_expected();
      send_cw(1'b0);
      check_result("R2", $sformatf("random %0d", r));
    end
  endtask

  task automatic t_gaps();
    for (int b = 0; b < CW; b++) cw[b] = 8'($urandom);
    calc_expected();
    send_cw(1'b1);
    check_result("R7", "gapped word");
  endtask

  task automatic t_hold();
    logic [NS*M-1:0] snap;
    logic            f;
    for (int b = 0; b < CW; b++) cw[b] = 8'($urandom);
    calc_expected();
    send_cw(1'b0);
    check_result("R2", "pre-hold");
    snap = syn_vec; f = err_flag;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b1; in_eoc = 1'b1; in_data = 8'($urandom);
    end
    @(negedge clk);
    idle_beat();
    chk(syn_vec == snap, "R5", "syndromes held", 32'(syn_vec[31:0]), 32'(snap[31:0]));
    chk_syn("R5", "held");
    chk(err_flag == f, "R5", "flag held", 32'(err_flag), 32'(f));
    chk(syn_valid == 1'b0, "R7", "no strobe from idle eoc", 32'(syn_valid), 32'd0);
  endtask

  task automatic t_back_to_back();
    for (int b = 0; b < CW; b++) cw[b] = 8'($urandom);
    cw[3] = 8'h5A;
    calc_expected();
    send_cw(1'b0);
    // strobe cycle: drive the next start beat in the same cycle
    @(negedge clk);
    chk(syn_valid == 1'b1, "R8", "b2b strobe", 32'(syn_valid), 32'd1);
    chk_syn("R8", "b2b old word");
    chk(err_flag == 1'b1, "R8", "b2b old flag", 32'(err_flag), 32'd1);
    for (int b = 0; b < CW; b++) cw[b] = 8'h00;
    in_valid = 1'b1; in_sof = 1'b1; in_eoc = 1'b0; in_data = 8'h00;
    @(negedge clk);
    chk(syn_valid == 1'b0, "R4", "b2b strobe ends", 32'(syn_valid), 32'd0);
    chk(syn_vec == '0, "R3", "accumulators restarted", 32'(syn_vec[31:0]), 32'd0);
    for (int b = 1; b < CW; b++) begin
      in_valid = 1'b1; in_sof = 1'b0; in_eoc = (b == CW - 1); in_data = 8'h00;
      @(negedge clk);
    end
    idle_beat();
    calc_expected();
    chk(syn_valid == 1'b1, "R8", "second strobe", 32'(syn_valid), 32'd1);
    chk_syn("R3", "second word");
    chk(err_flag == 1'b0, "R6", "second flag", 32'(err_flag), 32'd0);
  endtask

  // ---------------- sequencing ----------------
  initial begin
    idle_beat();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_zero_word();
    t_last_bit();
    repeat (2) @(negedge clk);
    t_first_bit();
    repeat (2) @(negedge clk);
    t_random(3);
    t_gaps();
    t_hold();
    t_back_to_back();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule